// File: doc/BRIEF.md
# I3C Transfer Word Sequencer

The sequencer takes one transfer command at a time and breaks it into an ordered list of bus words. It hands each word to a bit-level modulator, which drives the serial bus. A command names the target address, the direction, the byte count and a tag. It also carries three flags: whether to lead with the broadcast header, whether the target is a legacy I2C device, and whether the target is present on the bus.

Only one word is in flight at any time. The sequencer offers a word and waits for the modulator to return a response before it picks the next one. The response carries the acknowledge result, the peripheral's continuation bit and any received byte.

Transmit bytes come from a byte stream, one byte per data word. Received bytes go out on a separate stream. Each command ends with a one-cycle receipt that gives the byte count actually moved, an error code and the command's tag echoed back.

Top module: `i3c_word_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `word_valid`, `tx_ready`, `rx_valid` and `rcpt_valid` are 0.
- R2: Word kind codes are: 0 header, 1 address, 2 I3C write byte, 3 I2C write byte, 4 I3C read byte, 5 I2C read byte, 6 repeated start, 7 stop.
- R2 (sequence): An I3C transfer with the header flag set issues, in this order: header (data 0xFC, that is address 0x7E with the write bit), repeated start, address, the data words, then stop. With the header flag clear, the sequence starts at the address word.
- R2 (address data): The address word carries `{addr, rnw}`.
- R3: A target marked I2C never gets the header, even when the header flag is set. I2C writes use kind 3 and I2C reads use kind 5. I3C writes use kind 2 and I3C reads use kind 4.
- R4: A NACK on the header or on the address is followed directly by a stop, with no repeated start. The receipt then shows error 1 and length 0.
- R5: A NACK on an I2C write byte ends the transfer with a stop. The receipt shows error 1, and its length is the number of bytes acknowledged before that byte.
- R6: A write word is offered only while `tx_valid` is 1. The byte is taken (`tx_ready`) in the same cycle the word is accepted, and the word's data equals that byte.
- R7: An I3C read pushes each received byte on `rx_valid`/`rx_data`. It ends after the byte whose `resp_more` is 0, or when the programmed length is reached, whichever comes first. The receipt length is the number of bytes pushed.
- R8: An I2C read that still has `resp_more` at 1 after the programmed length keeps issuing read words until `resp_more` is 0. Those extra bytes are not pushed. The receipt shows error 2 and the programmed length.
- R9: The receipt is a one-cycle pulse carrying the command tag. On success it shows error 0 and the full length. A zero-length command goes straight from the address word to the stop.
- R10: A command whose target is not present issues no words. Its receipt shows error 3 and length 0.
- R11: With `IGNORE_NACK` set to 1, every NACK is treated as an acknowledge and the transfer runs to its full length.
- R12: `cmd_ready` is 1 only while no transfer is in progress. While it is 1, no word is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_addr | input | 7 | Target address |
| cmd_rnw | input | 1 | 1 for read, 0 for write |
| cmd_len | input | LEN_W | Programmed byte count |
| cmd_hdr | input | 1 | Lead with broadcast header |
| cmd_legacy | input | 1 | Target is an I2C device |
| cmd_present | input | 1 | Target is attached |
| cmd_tag | input | TAG_W | Tag echoed in the receipt |
| word_valid | output | 1 | Word offered to the modulator |
| word_ready | input | 1 | Modulator accepts the word |
| word_kind | output | 3 | Word kind code |
| word_data | output | 8 | Word payload |
| resp_valid | input | 1 | Modulator finished the word |
| resp_nack | input | 1 | Peripheral did not acknowledge |
| resp_more | input | 1 | Peripheral continues after this read byte |
| resp_data | input | 8 | Received byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Transmit byte taken |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| rcpt_valid | output | 1 | Receipt strobe |
| rcpt_len | output | LEN_W | Bytes transferred |
| rcpt_err | output | 2 | 0 ok, 1 NACK, 2 malformed read, 3 absent |
| rcpt_tag | output | TAG_W | Echoed command tag |

## Verification
A wrong state value shows up at the very next word handshake. The `word_kind` offered would differ from the expected sequence, or a word would be offered while `cmd_ready` is 1. A lost waiting flag would either stall the word stream or issue a second word before the response arrives, and the per-transfer word log exposes this within a few cycles. A wrong byte count or a stuck overrun flag surfaces only at the receipt, which appears at most one stop word after the last data word. The sweep therefore compares the full word log, the received bytes and the receipt for every combination of device type, direction, header use, length and peripheral behaviour.

// File: rtl/i3c_wseq_pkg.sv
package i3c_wseq_pkg;
  typedef enum logic [2:0] {
    WK_HDR    = 3'd0,
    WK_ADDR   = 3'd1,
    WK_WR3    = 3'd2,
    WK_WR2    = 3'd3,
    WK_RD3    = 3'd4,
    WK_RD2    = 3'd5,
    WK_RSTART = 3'd6,
    WK_STOP   = 3'd7
  } wkind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_HDR, S_RSTART, S_ADDR, S_DATA, S_STOP, S_RCPT
  } seq_st_e;

  localparam logic [1:0] E_OK     = 2'd0;
  localparam logic [1:0] E_NACK   = 2'd1;
  localparam logic [1:0] E_MALF   = 2'd2;
  localparam logic [1:0] E_ABSENT = 2'd3;

  localparam logic [6:0] HDR_ADDR = 7'h7E;
endpackage

// File: rtl/i3c_wseq_cnt.sv
module i3c_wseq_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] cnt,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  // byte being completed now is the final programmed one
  assign last = (({1'b0, cnt_q} + (LEN_W+1)'(1)) == {1'b0, len});
  assign cnt  = cnt_q;
endmodule

// File: rtl/i3c_wseq_word.sv
module i3c_wseq_word
  import i3c_wseq_pkg::*;
(
  input  seq_st_e    st,
  input  logic [6:0] addr,
  input  logic       rnw,
  input  logic       legacy,
  input  logic [7:0] tx_byte,
  output wkind_e     kind,
  output logic [7:0] data
);
  always_comb begin
    kind = WK_STOP;
    data = 8'h00;
    unique case (st)
      S_HDR:    begin kind = WK_HDR;    data = {HDR_ADDR, 1'b0}; end
      S_RSTART: begin kind = WK_RSTART; end
      S_ADDR:   begin kind = WK_ADDR;   data = {addr, rnw}; end
      S_DATA: begin
        if (rnw) kind = legacy ? WK_RD2 : WK_RD3;
        else begin
          kind = legacy ? WK_WR2 : WK_WR3;
          data = tx_byte;
        end
      end
      default: begin kind = WK_STOP; end
    endcase
  end
endmodule

// File: rtl/i3c_word_seq.sv
module i3c_word_seq
  import i3c_wseq_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int TAG_W       = 4,
  parameter int IGNORE_NACK = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_addr,
  input  logic             cmd_rnw,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_hdr,
  input  logic             cmd_legacy,
  input  logic             cmd_present,
  input  logic [TAG_W-1:0] cmd_tag,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [2:0]       word_kind,
  output logic [7:0]       word_data,
  input  logic             resp_valid,
  input  logic             resp_nack,
  input  logic             resp_more,
  input  logic [7:0]       resp_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rcpt_valid,
  output logic [LEN_W-1:0] rcpt_len,
  output logic [1:0]       rcpt_err,
  output logic [TAG_W-1:0] rcpt_tag
);
  localparam logic IGN = (IGNORE_NACK != 0);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  seq_st_e          st_q, st_d;
  logic             wt_q, wt_d;
  logic             ovr_q, ovr_d;
  logic [1:0]       err_q, err_d;
  logic             rxv_q, rxv_d;
  logic [7:0]       rxd_q, rxd_d;
  logic             load, clr, inc;

  logic [6:0]       c_addr;
  logic             c_rnw, c_hdr, c_leg, c_pres;
  logic [LEN_W-1:0] c_len;
  logic [TAG_W-1:0] c_tag;

  logic [LEN_W-1:0] cnt;
  logic             last;
  wkind_e           kind_w;
  logic             issue, is_wr, hs, got, nack_eff;

  i3c_wseq_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .clr(clr), .inc(inc),
    .len(c_len), .cnt(cnt), .last(last)
  );

  i3c_wseq_word u_word (
    .st(st_q), .addr(c_addr), .rnw(c_rnw), .legacy(c_leg),
    .tx_byte(tx_data), .kind(kind_w), .data(word_data)
  );

  assign issue      = (st_q == S_HDR) || (st_q == S_RSTART) || (st_q == S_ADDR) ||
                      (st_q == S_DATA) || (st_q == S_STOP);
  assign is_wr      = (st_q == S_DATA) && !c_rnw;
  assign word_valid = issue && !wt_q && (!is_wr || tx_valid);
  assign hs         = word_valid && word_ready;
  assign tx_ready   = hs && is_wr;
  assign got        = wt_q && resp_valid;
  assign nack_eff   = resp_nack && !IGN;
  assign word_kind  = kind_w;

  always_comb begin
    st_d  = st_q;
    wt_d  = wt_q;
    ovr_d = ovr_q;
    err_d = err_q;
    rxv_d = 1'b0;
    rxd_d = rxd_q;
    load  = 1'b0;
    clr   = 1'b0;
    inc   = 1'b0;
    if (hs)  wt_d = 1'b1;
    if (got) wt_d = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_valid) begin
        load = 1'b1;
        clr  = 1'b1;
        st_d = S_CHECK;
      end
      S_CHECK: begin
        ovr_d = 1'b0;
        err_d = E_OK;
        if (!c_pres) begin
          err_d = E_ABSENT;
          st_d  = S_RCPT;
        end else if (c_hdr && !c_leg) st_d = S_HDR;
        else                          st_d = S_ADDR;
      end
      S_HDR: if (got) begin
        if (nack_eff) begin err_d = E_NACK; st_d = S_STOP; end
        else st_d = S_RSTART;
      end
      S_RSTART: if (got) st_d = S_ADDR;
      S_ADDR: if (got) begin
        if (nack_eff) begin err_d = E_NACK; st_d = S_STOP; end
        else if (c_len == '0) st_d = S_STOP;
        else st_d = S_DATA;
      end
      S_DATA: if (got) begin
        if (!c_rnw) begin
          if (c_leg && nack_eff) begin err_d = E_NACK; st_d = S_STOP; end
          else begin
            inc = 1'b1;
            if (last) st_d = S_STOP;
          end
        end else if (ovr_q) begin
          if (!resp_more) st_d = S_STOP;
        end else begin
          rxv_d = 1'b1;
          rxd_d = resp_data;
          inc   = 1'b1;
          if (!resp_more) st_d = S_STOP;
          else if (last) begin
            if (c_leg) begin ovr_d = 1'b1; err_d = E_MALF; end
            else st_d = S_STOP;
          end
        end
      end
      S_STOP: if (got) st_d = S_RCPT;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q  <= S_IDLE;
      wt_q  <= 1'b0;
      ovr_q <= 1'b0;
      err_q <= E_OK;
      rxv_q <= 1'b0;
      rxd_q <= 8'h00;
    end else begin
      st_q  <= st_d;
      wt_q  <= wt_d;
      ovr_q <= ovr_d;
      err_q <= err_d;
      rxv_q <= rxv_d;
      rxd_q <= rxd_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      c_addr <= '0; c_rnw <= 1'b0; c_len <= '0; c_hdr <= 1'b0;
      c_leg  <= 1'b0; c_pres <= 1'b0; c_tag <= '0;
    end else if (load) begin
      c_addr <= cmd_addr; c_rnw <= cmd_rnw; c_len <= cmd_len; c_hdr <= cmd_hdr;
      c_leg  <= cmd_legacy; c_pres <= cmd_present; c_tag <= cmd_tag;
    end
  end

  assign cmd_ready  = (st_q == S_IDLE);
  assign rx_valid   = rxv_q;
  assign rx_data    = rxd_q;
  assign rcpt_valid = (st_q == S_RCPT);
  assign rcpt_len   = cnt;
  assign rcpt_err   = err_q;
  assign rcpt_tag   = c_tag;
endmodule

// File: rtl/i3c_word_seq_chk.sv
module i3c_word_seq_chk
  import i3c_wseq_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int IGNORE_NACK = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             word_valid,
  input logic             word_ready,
  input logic [2:0]       word_kind,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             resp_valid,
  input logic             resp_nack,
  input logic             rcpt_valid,
  input logic [1:0]       rcpt_err,
  input logic [LEN_W-1:0] rcpt_len
);
  logic [2:0] last_kind;
  logic       exp_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_kind <= WK_STOP;
      exp_stop  <= 1'b0;
    end else begin
      if (word_valid && word_ready) last_kind <= word_kind;
      if (resp_valid && resp_nack && (IGNORE_NACK == 0) &&
          (last_kind == WK_HDR || last_kind == WK_ADDR || last_kind == WK_WR2))
        exp_stop <= 1'b1;
      else if (word_valid && word_ready)
        exp_stop <= 1'b0;
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_kind)); // R2
  AST_TX_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> word_valid && word_ready && tx_valid &&
                 (word_kind == WK_WR3 || word_kind == WK_WR2)); // R6
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && exp_stop |-> word_kind == WK_STOP); // R4
  AST_ABSENT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rcpt_valid && rcpt_err == E_ABSENT |-> rcpt_len == '0); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !word_valid); // R12
  AST_RCPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rcpt_valid |=> !rcpt_valid && cmd_ready); // R9
endmodule

bind i3c_word_seq i3c_word_seq_chk #(.LEN_W(LEN_W), .IGNORE_NACK(IGNORE_NACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .word_valid(word_valid),
  .word_ready(word_ready), .word_kind(word_kind), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .resp_valid(resp_valid), .resp_nack(resp_nack),
  .rcpt_valid(rcpt_valid), .rcpt_err(rcpt_err), .rcpt_len(rcpt_len)
);

// File: tb/i3c_word_seq_bench.sv
module i3c_word_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;
  localparam int TAG_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready, cmd_rnw = 1'b0, cmd_hdr = 1'b0;
  logic cmd_legacy = 1'b0, cmd_present = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [TAG_W-1:0] cmd_tag = '0;
  logic word_valid, word_ready = 1'b1;
  logic [2:0] word_kind;
  logic [7:0] word_data;
  logic resp_valid = 1'b0, resp_nack = 1'b0, resp_more = 1'b0;
  logic [7:0] resp_data = '0;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic rx_valid;
  logic [7:0] rx_data;
  logic rcpt_valid;
  logic [LEN_W-1:0] rcpt_len;
  logic [1:0] rcpt_err;
  logic [TAG_W-1:0] rcpt_tag;

  i3c_word_seq #(.LEN_W(LEN_W), .TAG_W(TAG_W), .IGNORE_NACK(0)) u_i3c_word_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_rnw(cmd_rnw), .cmd_len(cmd_len), .cmd_hdr(cmd_hdr),
    .cmd_legacy(cmd_legacy), .cmd_present(cmd_present), .cmd_tag(cmd_tag),
    .word_valid(word_valid), .word_ready(word_ready), .word_kind(word_kind),
    .word_data(word_data), .resp_valid(resp_valid), .resp_nack(resp_nack),
    .resp_more(resp_more), .resp_data(resp_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .rcpt_valid(rcpt_valid), .rcpt_len(rcpt_len), .rcpt_err(rcpt_err), .rcpt_tag(rcpt_tag));

  // second copy with NACKs ignored, its own peripheral that never acknowledges
  logic i_cmd_valid = 1'b0, i_cmd_ready, i_word_valid, i_resp_valid = 1'b0;
  logic [2:0] i_word_kind;
  logic [7:0] i_word_data, i_rx_data;
  logic i_tx_ready, i_rx_valid, i_rcpt_valid;
  logic [LEN_W-1:0] i_rcpt_len;
  logic [1:0] i_rcpt_err;
  logic [TAG_W-1:0] i_rcpt_tag;

  i3c_word_seq #(.LEN_W(LEN_W), .TAG_W(TAG_W), .IGNORE_NACK(1)) u_i3c_word_seq_ign (
    .clk(clk), .rst_n(rst_n), .cmd_valid(i_cmd_valid), .cmd_ready(i_cmd_ready),
    .cmd_addr(7'h21), .cmd_rnw(1'b0), .cmd_len(8'd2), .cmd_hdr(1'b1),
    .cmd_legacy(1'b0), .cmd_present(1'b1), .cmd_tag(4'd9),
    .word_valid(i_word_valid), .word_ready(1'b1), .word_kind(i_word_kind),
    .word_data(i_word_data), .resp_valid(i_resp_valid), .resp_nack(1'b1),
    .resp_more(1'b0), .resp_data(8'h00), .tx_valid(1'b1),
    .tx_ready(i_tx_ready), .tx_data(8'h55), .rx_valid(i_rx_valid), .rx_data(i_rx_data),
    .rcpt_valid(i_rcpt_valid), .rcpt_len(i_rcpt_len), .rcpt_err(i_rcpt_err), .rcpt_tag(i_rcpt_tag));

  int total = 0, bad = 0;

  // peripheral model settings, written by the main sequence
  logic p_ack_hdr, p_ack_addr;
  int   p_nack_at, p_avail, p_gap;
  // logs, written by the responder
  int   n_words, n_rx, tx_idx, rx_idx, gap_cnt;
  logic got_rcpt;
  logic [2:0] lk [16];
  logic [7:0] ld [16];
  logic [7:0] lrx [16];
  logic [LEN_W-1:0] g_len;
  logic [1:0] g_err;
  logic [TAG_W-1:0] g_tag;
  int   i_words;
  logic i_got;
  logic [LEN_W-1:0] i_len;
  logic [1:0] i_err;

  function automatic logic [7:0] txb(int i); return 8'(i * 29 + 3); endfunction
  function automatic logic [7:0] rxb(int i); return 8'(i * 53 + 17); endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // responder for the main instance
  initial begin
    logic pend;
    logic [2:0] pk;
    pend = 1'b0; pk = '0;
    forever begin
      @(negedge clk);
      resp_valid = 1'b0;
      if (pend) begin
        resp_nack = 1'b0; resp_more = 1'b0; resp_data = 8'h00;
        case (pk)
          3'd0: resp_nack = !p_ack_hdr;
          3'd1: resp_nack = !p_ack_addr;
          3'd2, 3'd3: begin
            resp_nack = (pk == 3'd3) && (tx_idx == p_nack_at);
            tx_idx++; gap_cnt = p_gap;
          end
          3'd4, 3'd5: begin
            resp_data = rxb(rx_idx);
            resp_more = (rx_idx + 1 < p_avail);
            rx_idx++;
          end
          default: ;
        endcase
        resp_valid = 1'b1;
        pend = 1'b0;
      end
      if (gap_cnt > 0) begin tx_valid = 1'b0; gap_cnt--; end
      else tx_valid = 1'b1;
      tx_data = txb(tx_idx);
      #1;
      if (word_valid && word_ready) begin
        if (n_words < 16) begin lk[n_words] = word_kind; ld[n_words] = word_data; end
        n_words++; pend = 1'b1; pk = word_kind;
      end
      if (rx_valid) begin
        if (n_rx < 16) lrx[n_rx] = rx_data;
        n_rx++;
      end
      if (rcpt_valid) begin
        got_rcpt = 1'b1; g_len = rcpt_len; g_err = rcpt_err; g_tag = rcpt_tag;
      end
    end
  end

  // responder for the NACK-ignoring instance
  initial begin
    logic ipend;
    ipend = 1'b0;
    forever begin
      @(negedge clk);
      i_resp_valid = ipend;
      ipend = 1'b0;
      #1;
      if (i_word_valid) begin ipend = 1'b1; i_words++; end
      if (i_rcpt_valid) begin i_got = 1'b1; i_len = i_rcpt_len; i_err = i_rcpt_err; end
    end
  end

  task automatic run(input bit leg, input bit rnw, input bit hdr, input int len,
                     input int sc, input bit pres, input int tag);
    int ek [16];
    int ed [16];
    int en, elen, eerr, erx, m, rk;
    bit done;
    string req;
    logic [6:0] a;
    a = 7'(7'h10 + len * 3 + sc * 11);
    p_ack_hdr  = !(sc == 3 && hdr && !leg);
    p_ack_addr = !(sc == 3 && !(hdr && !leg));
    p_nack_at  = (!rnw && leg && sc == 1) ? 0 : (!rnw && leg && sc == 2 && len > 0) ? len - 1 : -1;
    p_avail    = !rnw ? 0 : (sc == 1) ? 1 : (sc == 2) ? len + 2 : (len == 0 ? 1 : len);
    p_gap      = sc;
    n_words = 0; n_rx = 0; tx_idx = 0; rx_idx = 0; gap_cnt = 0; got_rcpt = 1'b0;
    // expected sequence from the requirements
    en = 0; elen = 0; eerr = 0; erx = 0; done = 0;
    for (int k = 0; k < 16; k++) begin ek[k] = -1; ed[k] = -1; end
    req = rnw ? (leg ? "R8" : "R7") : "R6";
    if (!pres) begin done = 1; eerr = 3; req = "R10"; end
    if (!done && hdr && !leg) begin
      ek[en] = 0; ed[en] = 8'hFC; en++;
      if (!p_ack_hdr) begin ek[en] = 7; en++; eerr = 1; done = 1; req = "R4"; end
      else begin ek[en] = 6; en++; end
    end
    if (!done) begin
      ek[en] = 1; ed[en] = {a, rnw}; en++;
      if (!p_ack_addr) begin eerr = 1; req = "R4"; end
      else if (len == 0) req = "R9";
      else if (!rnw) begin
        elen = len;
        for (int i = 0; i < len; i++) if (!done) begin
          ek[en] = leg ? 3 : 2; ed[en] = txb(i); en++;
          if (leg && p_nack_at == i) begin done = 1; elen = i; eerr = 1; req = "R5"; end
        end
      end else begin
        rk = leg ? 5 : 4;
        if (!leg) begin m = (len < p_avail) ? len : p_avail; elen = m; erx = m; end
        else if (p_avail <= len) begin m = p_avail; elen = m; erx = m; end
        else begin m = p_avail; elen = len; erx = len; eerr = 2; end
        for (int i = 0; i < m; i++) begin ek[en] = rk; en++; end
      end
      ek[en] = 7; en++;
    end
    if (leg && hdr && req != "R4") req = "R3";
    // issue the command
    cmd_addr = a; cmd_rnw = rnw; cmd_len = LEN_W'(len); cmd_hdr = hdr;
    cmd_legacy = leg; cmd_present = pres; cmd_tag = TAG_W'(tag);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int t = 0; t < 300 && !got_rcpt; t++) @(negedge clk);
    #2;
    check(got_rcpt, req, "receipt seen", int'(got_rcpt), 1);
    check(g_err == 2'(eerr), req, "receipt error", int'(g_err), eerr);
    check(g_len == LEN_W'(elen), req, "receipt length", int'(g_len), elen);
    check(g_tag == TAG_W'(tag), "R9", "receipt tag", int'(g_tag), tag);
    check(n_words == en, req, "word count", n_words, en);
    for (int k = 0; k < en && k < 16 && k < n_words; k++) begin
      check(int'(lk[k]) == ek[k], leg ? "R3" : "R2", "word kind", int'(lk[k]), ek[k]);
      if (ed[k] >= 0) check(int'(ld[k]) == ed[k], (ek[k] >= 2) ? "R6" : "R2", "word data", int'(ld[k]), ed[k]);
    end
    check(n_rx == erx, req, "rx count", n_rx, erx);
    for (int k = 0; k < erx && k < n_rx && k < 16; k++)
      check(lrx[k] == rxb(k), req, "rx byte", int'(lrx[k]), int'(rxb(k)));
    for (int t = 0; t < 10 && !cmd_ready; t++) @(negedge clk);
    check(cmd_ready, "R12", "ready after receipt", int'(cmd_ready), 1);
  endtask

  initial begin
    int tag;
    tag = 0; i_words = 0; i_got = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_ready === 1'b1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
    check(word_valid === 1'b0 && tx_ready === 1'b0, "R1", "word/tx idle", int'(word_valid), 0);
    check(rx_valid === 1'b0 && rcpt_valid === 1'b0, "R1", "rx/rcpt idle", int'(rcpt_valid), 0);
    for (int leg = 0; leg < 2; leg++)
      for (int rnw = 0; rnw < 2; rnw++)
        for (int hdr = 0; hdr < 2; hdr++)
          for (int len = 0; len < 5; len++)
            for (int sc = 0; sc < 4; sc++) begin
              run(leg[0], rnw[0], hdr[0], len, sc, 1'b1, tag);
              tag++;
            end
    for (int leg = 0; leg < 2; leg++) begin
      run(leg[0], 1'b0, 1'b1, 3, 0, 1'b0, tag);
      tag++;
    end
    // R11: all NACKs ignored on the second copy
    i_cmd_valid = 1'b1;
    @(negedge clk);
    i_cmd_valid = 1'b0;
    for (int t = 0; t < 100 && !i_got; t++) @(negedge clk);
    #2;
    check(i_got, "R11", "receipt seen", int'(i_got), 1);
    check(i_err == 2'd0, "R11", "error ignored", int'(i_err), 0);
    check(i_len == 8'd2, "R11", "full length", int'(i_len), 2);
    check(i_words == 6, "R11", "word count", i_words, 6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule